// File: doc/BRIEF.md
# Real-Time-Clock Register Traffic Monitor

This block sits beside a two-wire serial bus as a passive observer. It does not sample the bus wires itself. Instead, it consumes a stream of already-decoded bus events. Each event carries a kind code and one byte, and it arrives with a one-cycle valid qualifier. From this stream the block follows register accesses aimed at one real-time-clock target.

While it follows the traffic, it keeps an auto-incrementing register pointer. It emits a one-cycle strobe, with register index and byte, for every register written or read. It converts the packed-decimal time and date fields into binary registers. It also extracts the supply-low flag, the century flag and the control/status bits.

A stop at the end of a data phase produces a completion strobe tagged as read or write. Software-visible logic or a trace buffer can use these outputs to reconstruct what the bus master did to the clock chip without touching the bus.

Top module: `rtc_bus_monitor`

## Requirements
- R1: Event kinds on `evt_kind` are 0 start, 1 repeated start, 2 stop, 3 address-write, 4 address-read, 5 data-write and 6 data-read; code 7 matches nothing. From idle, only a start (0) begins a transaction. Every other event seen in idle produces no strobe.
- R2: After a start, the block waits for an address-write whose byte is 0xA2. The first data-write after that loads the pointer from bits 3..0 of its byte and produces no register strobe.
- R3: In the write phase, each data-write gives, one cycle later, `reg_strobe`=1 with `reg_is_read`=0, `reg_index` equal to the pointer and `reg_value` equal to the byte. The pointer then increments, wrapping from 15 to 0. Each strobe lasts exactly one cycle.
- R4: A repeated start in the write phase leads to a wait for an address-read whose byte is 0xA3. After that, each data-read gives a strobe with `reg_is_read`=1 at the current pointer, and the pointer keeps incrementing from where the write phase left it.
- R5: A stop in the write or read data phase gives a one-cycle `done_strobe` one cycle later and returns to idle. `done_is_read` is 0 after a write phase and 1 after a read phase.
- R6: If the address-write byte is not 0xA2, or the address-read byte is not 0xA3, the block emits no strobes and no completion. It returns to idle at the next stop.
- R7: Within any non-idle state, an event kind that state does not expect is ignored and changes nothing.
- R8: Register 2 updates seconds from bits 6..0 and `volt_low` from bit 7. Register 3 updates minutes from bits 6..0, with bit 7 ignored. Each packed-decimal value converts as low nibble plus ten times high nibble. Both written and read bytes update the fields.
- R9: Register 4 updates hours and register 5 updates day of month, each from bits 5..0, with bits 7..6 ignored.
- R10: Register 6 updates weekday from bits 2..0. Register 7 updates month from bits 4..0 and `century` from bit 7. Register 8 updates year from all eight bits.
- R11: Register 1 updates `timer_repeat` (bit 4), `alarm_flag` (bit 3), `timer_flag` (bit 2), `alarm_irq_en` (bit 1) and `timer_irq_en` (bit 0). Registers 0 and 9..15 affect no decoded output.
- R12: After reset, all outputs are 0. `field_valid` bits are ordered seconds (0), minutes (1), hours (2), day (3), weekday (4), month (5), year (6). A start from idle clears them all. A bit is set when its field is updated. Field values hold across transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 3 | Event kind code |
| evt_byte | input | 8 | Byte carried by the event |
| reg_strobe | output | 1 | One-cycle register access pulse |
| reg_is_read | output | 1 | Access was a read (valid with strobe) |
| reg_index | output | 4 | Register index of the access |
| reg_value | output | 8 | Byte of the access |
| done_strobe | output | 1 | One-cycle transaction completion pulse |
| done_is_read | output | 1 | Completed transaction was a read |
| rtc_seconds | output | 8 | Seconds in binary |
| rtc_minutes | output | 8 | Minutes in binary |
| rtc_hours | output | 8 | Hours in binary |
| rtc_day | output | 8 | Day of month in binary |
| rtc_weekday | output | 8 | Weekday in binary |
| rtc_month | output | 8 | Month in binary |
| rtc_year | output | 8 | Year in binary |
| field_valid | output | 7 | Per-field update flags for this transaction |
| volt_low | output | 1 | Supply-low flag |
| century | output | 1 | Century flag |
| timer_repeat | output | 1 | Timer interrupt repeat mode |
| alarm_flag | output | 1 | Alarm event flag |
| timer_flag | output | 1 | Timer event flag |
| alarm_irq_en | output | 1 | Alarm interrupt enable |
| timer_irq_en | output | 1 | Timer interrupt enable |

## Verification
Every result of an event lands on the clock edge that samples that event: the strobes, the completion pulse, the field values, the flags and the valid bits. So each one is readable one cycle after the event is presented, and the pulses clear again on the following edge. The bench presents each event at a falling edge, waits through the next rising edge, and compares every output against its reference model at the falling edge after that. Idle gaps between events confirm that the pulses last no longer than one cycle.

// File: rtl/rtc_mon_pkg.sv
package rtc_mon_pkg;

    typedef enum logic [2:0] {
        EV_START    = 3'd0,
        EV_RESTART  = 3'd1,
        EV_STOP     = 3'd2,
        EV_ADDR_WR  = 3'd3,
        EV_ADDR_RD  = 3'd4,
        EV_DATA_WR  = 3'd5,
        EV_DATA_RD  = 3'd6
    } ev_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_AW,
        S_WAIT_PTR,
        S_WRITE,
        S_WAIT_AR,
        S_READ,
        S_SKIP
    } mon_state_e;

    localparam int NUM_TIME      = 7;
    localparam int TIME_REG_BASE = 2;
    localparam int CTRL_REG      = 1;
    localparam int SEC_FIELD     = 0;
    localparam int MONTH_FIELD   = 5;

    // packed decimal byte to binary: low digit plus ten times high digit
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return {4'd0, b[3:0]} + ({4'd0, b[7:4]} * 8'd10);
    endfunction

    // significant bits of each time field, field i lives at register i+2
    function automatic logic [7:0] field_mask(input int i);
        case (i)
            0, 1:    return 8'h7F;
            2, 3:    return 8'h3F;
            4:       return 8'h07;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtc_mon_fsm.sv
module rtc_mon_fsm
    import rtc_mon_pkg::*;
#(
    parameter int         PTR_W    = 4,
    parameter logic [6:0] DEV_ADDR = 7'h51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [2:0]       evt_kind,
    input  logic [7:0]       evt_byte,
    output logic             apply_o,
    output logic [PTR_W-1:0] apply_idx_o,
    output logic [7:0]       apply_val_o,
    output logic             clear_o,
    output logic             strobe_o,
    output logic             strobe_rd_o,
    output logic [PTR_W-1:0] strobe_idx_o,
    output logic [7:0]       strobe_val_o,
    output logic             done_o,
    output logic             done_rd_o
);

    localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
    localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};

    typedef struct packed {
        mon_state_e       state;
        logic [PTR_W-1:0] ptr;
        logic             strobe;
        logic             strobe_rd;
        logic [PTR_W-1:0] idx;
        logic [7:0]       val;
        logic             done;
        logic             done_rd;
    } fsm_t;

    fsm_t     fsm_q, fsm_d;
    ev_kind_e kind;
    logic     take_byte;
    logic     take_rd;

    assign kind = ev_kind_e'(evt_kind);

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.strobe = 1'b0;
        fsm_d.done   = 1'b0;
        take_byte    = 1'b0;
        take_rd      = 1'b0;
        clear_o      = 1'b0;
        if (evt_valid) begin
            case (fsm_q.state)
                S_IDLE: begin
                    if (kind == EV_START) begin
                        fsm_d.state = S_WAIT_AW;
                        clear_o     = 1'b1;
                    end
                end
                S_WAIT_AW: begin
                    if (kind == EV_ADDR_WR)
                        fsm_d.state = (evt_byte == WR_ADDR) ? S_WAIT_PTR : S_SKIP;
                end
                S_WAIT_PTR: begin
                    if (kind == EV_DATA_WR) begin
                        fsm_d.ptr   = evt_byte[PTR_W-1:0];
                        fsm_d.state = S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (kind == EV_RESTART) begin
                        fsm_d.state = S_WAIT_AR;
                    end else if (kind == EV_DATA_WR) begin
                        take_byte = 1'b1;
                    end else if (kind == EV_STOP) begin
                        fsm_d.done    = 1'b1;
                        fsm_d.done_rd = 1'b0;
                        fsm_d.state   = S_IDLE;
                    end
                end
                S_WAIT_AR: begin
                    if (kind == EV_ADDR_RD)
                        fsm_d.state = (evt_byte == RD_ADDR) ? S_READ : S_SKIP;
                end
                S_READ: begin
                    if (kind == EV_DATA_RD) begin
                        take_byte = 1'b1;
                        take_rd   = 1'b1;
                    end else if (kind == EV_STOP) begin
                        fsm_d.done    = 1'b1;
                        fsm_d.done_rd = 1'b1;
                        fsm_d.state   = S_IDLE;
                    end
                end
                S_SKIP: begin
                    if (kind == EV_STOP)
                        fsm_d.state = S_IDLE;
                end
                default: fsm_d.state = S_IDLE;
            endcase
        end
        if (take_byte) begin
            fsm_d.strobe    = 1'b1;
            fsm_d.strobe_rd = take_rd;
            fsm_d.idx       = fsm_q.ptr;
            fsm_d.val       = evt_byte;
            fsm_d.ptr       = fsm_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{state: S_IDLE, default: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign apply_o      = take_byte;
    assign apply_idx_o  = fsm_q.ptr;
    assign apply_val_o  = evt_byte;
    assign strobe_o     = fsm_q.strobe;
    assign strobe_rd_o  = fsm_q.strobe_rd;
    assign strobe_idx_o = fsm_q.idx;
    assign strobe_val_o = fsm_q.val;
    assign done_o       = fsm_q.done;
    assign done_rd_o    = fsm_q.done_rd;

    // R3: after an access the pointer sits one past the reported index
    assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.strobe |-> (fsm_q.ptr == fsm_q.idx + PTR_W'(1)));

    // R5: completion is alone and leaves the monitor idle
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.done |-> (!fsm_q.strobe && fsm_q.state == S_IDLE));

    // R6: a foreign transaction never reports an access
    assert_skip_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == S_SKIP) |-> !fsm_q.strobe);

    // R1: leaving idle needs a start event
    assert_idle_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.state) == S_IDLE && fsm_q.state != S_IDLE)
            |-> ($past(evt_valid) && $past(evt_kind) == 3'd0));

endmodule

// File: rtl/rtc_mon_fields.sv
module rtc_mon_fields
    import rtc_mon_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          apply_i,
    input  logic [PTR_W-1:0]              idx_i,
    input  logic [7:0]                    val_i,
    input  logic                          clear_i,
    output logic [NUM_TIME-1:0][7:0]      time_o,
    output logic [NUM_TIME-1:0]           valid_o,
    output logic                          vl_o,
    output logic                          century_o,
    output logic [4:0]                    ctrl_o
);

    localparam logic [PTR_W-1:0] IDX_CTRL = PTR_W'(CTRL_REG);

    typedef struct packed {
        logic [NUM_TIME-1:0][7:0] tval;
        logic [NUM_TIME-1:0]      valid;
        logic                     vl;
        logic                     cent;
        logic [4:0]               ctrl;
    } fld_t;

    fld_t                fld_q, fld_d;
    logic [NUM_TIME-1:0] hit;

    for (genvar gi = 0; gi < NUM_TIME; gi++) begin : g_hit
        localparam logic [PTR_W-1:0] REG_IDX = PTR_W'(TIME_REG_BASE + gi);
        assign hit[gi] = apply_i && (idx_i == REG_IDX);
    end

    always_comb begin
        fld_d = fld_q;
        if (clear_i)
            fld_d.valid = '0;
        for (int i = 0; i < NUM_TIME; i++) begin
            if (hit[i]) begin
                fld_d.tval[i]  = bcd_to_bin(val_i & field_mask(i));
                fld_d.valid[i] = 1'b1;
            end
        end
        if (hit[SEC_FIELD])
            fld_d.vl = val_i[7];
        if (hit[MONTH_FIELD])
            fld_d.cent = val_i[7];
        if (apply_i && idx_i == IDX_CTRL)
            fld_d.ctrl = val_i[4:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign time_o    = fld_q.tval;
    assign valid_o   = fld_q.valid;
    assign vl_o      = fld_q.vl;
    assign century_o = fld_q.cent;
    assign ctrl_o    = fld_q.ctrl;

    // R12: a new transaction starts with no field marked
    assert_clear_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (fld_q.valid == '0));

    // R8: supply-low flag follows bit 7 of a seconds access
    assert_vl_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && idx_i == PTR_W'(TIME_REG_BASE)) |=> (fld_q.vl == $past(val_i[7])));

    // R10: century flag follows bit 7 of a month access
    assert_century_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && idx_i == PTR_W'(TIME_REG_BASE + MONTH_FIELD))
            |=> (fld_q.cent == $past(val_i[7])));

    // R11: control bits are untouched by any other register
    assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(apply_i && idx_i == IDX_CTRL) |=> $stable(fld_q.ctrl));

endmodule

// File: rtl/rtc_bus_monitor.sv
module rtc_bus_monitor
    import rtc_mon_pkg::*;
#(
    parameter int         PTR_W    = 4,
    parameter logic [6:0] DEV_ADDR = 7'h51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [2:0]       evt_kind,
    input  logic [7:0]       evt_byte,
    output logic             reg_strobe,
    output logic             reg_is_read,
    output logic [PTR_W-1:0] reg_index,
    output logic [7:0]       reg_value,
    output logic             done_strobe,
    output logic             done_is_read,
    output logic [7:0]       rtc_seconds,
    output logic [7:0]       rtc_minutes,
    output logic [7:0]       rtc_hours,
    output logic [7:0]       rtc_day,
    output logic [7:0]       rtc_weekday,
    output logic [7:0]       rtc_month,
    output logic [7:0]       rtc_year,
    output logic [6:0]       field_valid,
    output logic             volt_low,
    output logic             century,
    output logic             timer_repeat,
    output logic             alarm_flag,
    output logic             timer_flag,
    output logic             alarm_irq_en,
    output logic             timer_irq_en
);

    logic                     apply_w;
    logic [PTR_W-1:0]         apply_idx_w;
    logic [7:0]               apply_val_w;
    logic                     clear_w;
    logic [NUM_TIME-1:0][7:0] time_w;
    logic [4:0]               ctrl_w;

    rtc_mon_fsm #(
        .PTR_W    (PTR_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid    (evt_valid),
        .evt_kind     (evt_kind),
        .evt_byte     (evt_byte),
        .apply_o      (apply_w),
        .apply_idx_o  (apply_idx_w),
        .apply_val_o  (apply_val_w),
        .clear_o      (clear_w),
        .strobe_o     (reg_strobe),
        .strobe_rd_o  (reg_is_read),
        .strobe_idx_o (reg_index),
        .strobe_val_o (reg_value),
        .done_o       (done_strobe),
        .done_rd_o    (done_is_read)
    );

    rtc_mon_fields #(
        .PTR_W (PTR_W)
    ) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply_i   (apply_w),
        .idx_i     (apply_idx_w),
        .val_i     (apply_val_w),
        .clear_i   (clear_w),
        .time_o    (time_w),
        .valid_o   (field_valid),
        .vl_o      (volt_low),
        .century_o (century),
        .ctrl_o    (ctrl_w)
    );

    assign rtc_seconds  = time_w[0];
    assign rtc_minutes  = time_w[1];
    assign rtc_hours    = time_w[2];
    assign rtc_day      = time_w[3];
    assign rtc_weekday  = time_w[4];
    assign rtc_month    = time_w[5];
    assign rtc_year     = time_w[6];
    assign timer_repeat = ctrl_w[4];
    assign alarm_flag   = ctrl_w[3];
    assign timer_flag   = ctrl_w[2];
    assign alarm_irq_en = ctrl_w[1];
    assign timer_irq_en = ctrl_w[0];

endmodule

// File: tb/sim_rtc_bus_monitor.sv
module sim_rtc_bus_monitor;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] K_START = 3'd0;
    localparam logic [2:0] K_RSTRT = 3'd1;
    localparam logic [2:0] K_STOP  = 3'd2;
    localparam logic [2:0] K_AWR   = 3'd3;
    localparam logic [2:0] K_ARD   = 3'd4;
    localparam logic [2:0] K_DWR   = 3'd5;
    localparam logic [2:0] K_DRD   = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic [2:0] evt_kind = 3'd0;
    logic [7:0] evt_byte = 8'd0;

    logic       reg_strobe, reg_is_read, done_strobe, done_is_read;
    logic [3:0] reg_index;
    logic [7:0] reg_value;
    logic [7:0] rtc_seconds, rtc_minutes, rtc_hours, rtc_day;
    logic [7:0] rtc_weekday, rtc_month, rtc_year;
    logic [6:0] field_valid;
    logic       volt_low, century, timer_repeat, alarm_flag, timer_flag;
    logic       alarm_irq_en, timer_irq_en;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state: 0 idle,1 wait aw,2 wait ptr,3 write,4 wait ar,5 read,6 skip
    int         m_state = 0;
    logic [3:0] m_ptr   = 4'd0;
    logic [7:0] m_time [7];
    logic [6:0] m_valid = 7'd0;
    logic       m_vl    = 1'b0;
    logic       m_cent  = 1'b0;
    logic [4:0] m_ctrl  = 5'd0;

    rtc_bus_monitor u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_byte(evt_byte), .reg_strobe(reg_strobe), .reg_is_read(reg_is_read),
        .reg_index(reg_index), .reg_value(reg_value), .done_strobe(done_strobe),
        .done_is_read(done_is_read), .rtc_seconds(rtc_seconds),
        .rtc_minutes(rtc_minutes), .rtc_hours(rtc_hours), .rtc_day(rtc_day),
        .rtc_weekday(rtc_weekday), .rtc_month(rtc_month), .rtc_year(rtc_year),
        .field_valid(field_valid), .volt_low(volt_low), .century(century),
        .timer_repeat(timer_repeat), .alarm_flag(alarm_flag),
        .timer_flag(timer_flag), .alarm_irq_en(alarm_irq_en),
        .timer_irq_en(timer_irq_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ref_bcd(input logic [7:0] b);
        return 8'(int'(b[3:0]) + 10 * int'(b[7:4]));
    endfunction

    function automatic logic [7:0] ref_mask(input int f);
        case (f)
            0: return 8'h7F;  1: return 8'h7F;
            2: return 8'h3F;  3: return 8'h3F;
            4: return 8'h07;  5: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_apply(input logic [3:0] idx, input logic [7:0] b);
        if (idx == 4'd1) m_ctrl = b[4:0];
        if (idx >= 4'd2 && idx <= 4'd8) begin
            m_time[idx - 4'd2]  = ref_bcd(b & ref_mask(int'(idx) - 2));
            m_valid[idx - 4'd2] = 1'b1;
        end
        if (idx == 4'd2) m_vl   = b[7];
        if (idx == 4'd7) m_cent = b[7];
    endtask

    task automatic check_fields();
        chk("R8 seconds",  {24'd0, rtc_seconds}, {24'd0, m_time[0]});
        chk("R8 minutes",  {24'd0, rtc_minutes}, {24'd0, m_time[1]});
        chk("R9 hours",    {24'd0, rtc_hours},   {24'd0, m_time[2]});
        chk("R9 day",      {24'd0, rtc_day},     {24'd0, m_time[3]});
        chk("R10 weekday", {24'd0, rtc_weekday}, {24'd0, m_time[4]});
        chk("R10 month",   {24'd0, rtc_month},   {24'd0, m_time[5]});
        chk("R10 year",    {24'd0, rtc_year},    {24'd0, m_time[6]});
        chk("R12 valid",   {25'd0, field_valid}, {25'd0, m_valid});
        chk("R8 volt_low", {31'd0, volt_low},    {31'd0, m_vl});
        chk("R10 century", {31'd0, century},     {31'd0, m_cent});
        chk("R11 control", {27'd0, timer_repeat, alarm_flag, timer_flag,
                            alarm_irq_en, timer_irq_en}, {27'd0, m_ctrl});
    endtask

    // present one event at a falling edge; results are checked one cycle later
    task automatic send(input logic [2:0] k, input logic [7:0] b, input string tag = "");
        logic       e_str = 1'b0, e_rd = 1'b0, e_done = 1'b0, e_drd = 1'b0;
        logic [3:0] e_idx = 4'd0;
        string      st_tag;
        st_tag = (m_state == 0) ? "R1" : (m_state == 2) ? "R2" : (m_state == 6) ? "R6" :
                 (m_state == 5) ? "R4" : "R3";
        if (tag != "") st_tag = tag;
        case (m_state)
            0: if (k == K_START) begin m_state = 1; m_valid = '0; end
            1: if (k == K_AWR) m_state = (b == 8'hA2) ? 2 : 6;
            2: if (k == K_DWR) begin m_ptr = b[3:0]; m_state = 3; end
            3: begin
                if (k == K_RSTRT) m_state = 4;
                else if (k == K_DWR) begin
                    e_str = 1'b1; e_idx = m_ptr; model_apply(m_ptr, b); m_ptr = m_ptr + 4'd1;
                end else if (k == K_STOP) begin e_done = 1'b1; m_state = 0; end
            end
            4: if (k == K_ARD) m_state = (b == 8'hA3) ? 5 : 6;
            5: begin
                if (k == K_DRD) begin
                    e_str = 1'b1; e_rd = 1'b1; e_idx = m_ptr; model_apply(m_ptr, b);
                    m_ptr = m_ptr + 4'd1;
                end else if (k == K_STOP) begin e_done = 1'b1; e_drd = 1'b1; m_state = 0; end
            end
            6: if (k == K_STOP) m_state = 0;
            default: m_state = 0;
        endcase
        evt_valid = 1'b1; evt_kind = k; evt_byte = b;
        @(posedge clk);
        @(negedge clk);
        evt_valid = 1'b0;
        chk({st_tag, " strobe"}, {31'd0, reg_strobe}, {31'd0, e_str});
        if (e_str) begin
            chk(e_rd ? "R4 index" : "R3 index", {28'd0, reg_index}, {28'd0, e_idx});
            chk(e_rd ? "R4 value" : "R3 value", {24'd0, reg_value}, {24'd0, b});
            chk(e_rd ? "R4 dir" : "R3 dir", {31'd0, reg_is_read}, {31'd0, e_rd});
        end
        chk("R5 done", {31'd0, done_strobe}, {31'd0, e_done});
        if (e_done) chk("R5 done dir", {31'd0, done_is_read}, {31'd0, e_drd});
        check_fields();
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R3 pulse width", {31'd0, reg_strobe}, 32'd0);
            chk("R5 pulse width", {31'd0, done_strobe}, 32'd0);
        end
    endtask

    task automatic rand_txn();
        int         sel = int'($urandom % 5);
        int         len = int'($urandom % 7);
        logic [3:0] p   = 4'($urandom);
        send(K_START, 8'($urandom));
        case (sel)
            0: begin
                send(K_AWR, 8'hA2); send(K_DWR, {4'd0, p});
                for (int i = 0; i < len; i++) send(K_DWR, 8'($urandom));
                send(K_STOP, 8'd0);
            end
            1: begin
                send(K_AWR, 8'hA2); send(K_DWR, {4'd0, p});
                if (($urandom % 2) == 0) send(K_DWR, 8'($urandom));
                send(K_RSTRT, 8'd0); send(K_ARD, 8'hA3);
                for (int i = 0; i < len; i++) send(K_DRD, 8'($urandom));
                send(K_STOP, 8'd0);
            end
            2: begin
                send(K_AWR, 8'($urandom));
                for (int i = 0; i < len; i++) send(K_DWR, 8'($urandom));
                send(K_STOP, 8'd0);
            end
            default: begin
                for (int i = 0; i < 2 * len; i++) send(3'($urandom), 8'($urandom));
                send(K_STOP, 8'd0);
            end
        endcase
        gap(int'($urandom % 3));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog all-requirements act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 7; i++) m_time[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 reset strobe", {31'd0, reg_strobe}, 32'd0);
        chk("R12 reset done", {31'd0, done_strobe}, 32'd0);
        check_fields();

        // R1: non-start events in idle do nothing
        send(K_DWR, 8'h02, "R1");
        send(K_STOP, 8'h00, "R1");
        send(K_AWR, 8'hA2, "R1");
        send(K_DRD, 8'h55, "R1");

        // R2/R3/R8/R9/R10: full time write from register 2
        send(K_START, 8'h00);
        send(K_AWR, 8'hA2);
        send(K_DWR, 8'h02, "R2");
        send(K_DWR, 8'hD9);
        send(K_DWR, 8'hD9);
        send(K_DWR, 8'hE3);
        send(K_DWR, 8'hF1);
        send(K_DWR, 8'hFE);
        send(K_DWR, 8'h92);
        send(K_DWR, 8'h99);
        send(K_STOP, 8'h00);
        gap(2);

        // R11: control register, then register 0 and 9 change nothing
        send(K_START, 8'h00); send(K_AWR, 8'hA2); send(K_DWR, 8'h00);
        send(K_DWR, 8'hFF, "R11");
        send(K_DWR, 8'h1B, "R11");
        send(K_STOP, 8'h00);
        send(K_START, 8'h00); send(K_AWR, 8'hA2); send(K_DWR, 8'h09);
        for (int i = 0; i < 6; i++) send(K_DWR, 8'hFF, "R11");
        send(K_STOP, 8'h00);

        // R3: pointer wraps from 15 to 0
        send(K_START, 8'h00); send(K_AWR, 8'hA2); send(K_DWR, 8'h0E);
        for (int i = 0; i < 5; i++) send(K_DWR, 8'h10 + 8'(i), "R3 wrap");
        send(K_STOP, 8'h00);

        // R4: write pointer then read back through repeated start
        send(K_START, 8'h00); send(K_AWR, 8'hA2); send(K_DWR, 8'h01);
        send(K_DWR, 8'h04);
        send(K_RSTRT, 8'h00); send(K_ARD, 8'hA3);
        for (int i = 0; i < 8; i++) send(K_DRD, 8'h21 + 8'(i), "R4");
        send(K_STOP, 8'h00, "R5 read stop");

        // R6: foreign write address and foreign read address
        send(K_START, 8'h00); send(K_AWR, 8'hD0, "R6");
        send(K_DWR, 8'h02, "R6"); send(K_DWR, 8'h45, "R6");
        send(K_RSTRT, 8'h00, "R6"); send(K_DRD, 8'h11, "R6");
        send(K_STOP, 8'h00, "R6");
        send(K_START, 8'h00); send(K_AWR, 8'hA2); send(K_DWR, 8'h02);
        send(K_RSTRT, 8'h00); send(K_ARD, 8'hA5, "R6");
        send(K_DRD, 8'h33, "R6"); send(K_STOP, 8'h00, "R6");

        // R7: unexpected kinds in each state are ignored
        send(K_START, 8'h00);
        send(K_DWR, 8'h03, "R7"); send(K_RSTRT, 8'h00, "R7"); send(K_STOP, 8'h0, "R7");
        send(K_AWR, 8'hA2);
        send(K_DRD, 8'h04, "R7"); send(K_START, 8'h00, "R7");
        send(K_DWR, 8'h03);
        send(K_DRD, 8'h12, "R7"); send(K_ARD, 8'hA3, "R7"); send(3'd7, 8'h11, "R7");
        send(K_DWR, 8'h47);
        send(K_RSTRT, 8'h00);
        send(K_DRD, 8'h09, "R7"); send(K_STOP, 8'h00, "R7");
        send(K_ARD, 8'hA3);
        send(K_DWR, 8'h58, "R7"); send(K_START, 8'h00, "R7");
        send(K_DRD, 8'h12);
        send(K_STOP, 8'h00);

        // mixed random traffic
        for (int t = 0; t < 400; t++) rand_txn();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule